// File: doc/BRIEF.md
# Byte-Lane Word Memory Bus Slave

This block is a slave on a Wishbone classic bus. Behind it sits a synchronous on-chip memory of 64-bit words. A single master issues read and write cycles one at a time. Each cycle receives exactly one acknowledge pulse after a fixed latency of two clock edges.

Writes change only the byte lanes whose select bit is set. Reads always return the whole 64-bit word, whatever the select bits are. At start-up the memory holds a computed pattern: the byte at byte address n equals (n + `SEED`) mod 256. The synchronous reset does not change this content.

Flow control follows the classic handshake, with no stall signal. The master raises `bus_cyc` and `bus_stb` and holds the address, data, select and write-enable steady until it sees `bus_ack`. The slave applies back-pressure only by withholding the acknowledge. It accepts a new request only once the previous one has finished.

Top module: `wbram_slave`

## Requirements
- R1: Select bit i controls data bits 8i+7..8i, so on a write only the enabled bytes of the addressed word change.
- R2: The word index comes from address bits starting at bit 3. Bits 2..0 and all bits above the memory depth are ignored, so an address DEPTH*8 higher aliases to the same word.
- R3: Byte order is little-endian. With the default SEED of 0, word 0 reads as 0x0706050403020100 and word at address 8 as 0x0F0E0D0C0B0A0908.
- R4: The acknowledge is low when a request is first presented. A request is accepted at the first rising edge where cyc and stb are both high. The acknowledge rises after the next edge, together with valid read data.
- R5: The acknowledge lasts exactly one cycle. The edge that ends it accepts no new request.
- R6: A read returns all 64 bits regardless of the select bits.
- R7: Memory changes only when write-enable is high. A cycle with write-enable low leaves the memory unchanged even when the data bus carries a value.
- R8: A read issued right after a write returns the newly written bytes.
- R9: If cyc or stb is low at the edge after acceptance, the request is cancelled: no acknowledge is given and no write takes place.
- R10: Synchronous reset returns the handshake to idle with the acknowledge low, and keeps the memory contents.
- R11: The acknowledge output is high only while both cyc and stb are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Cycle in progress |
| bus_stb | input | 1 | Request strobe |
| bus_we | input | 1 | Write enable |
| bus_adr | input | ADDR_W | Byte address |
| bus_sel | input | DATA_W/8 | Byte-lane selects |
| bus_wdat | input | DATA_W | Write data |
| bus_rdat | output | DATA_W | Read data, valid while acknowledge is high |
| bus_ack | output | 1 | Single-cycle acknowledge |

## Verification
The hardest case to reach is a cancellation. The master must abandon a request in the single cycle between acceptance and the memory access. The bench reaches it by raising a write on a falling edge, letting one rising edge accept it, and dropping cyc and stb on the next falling edge. It then watches for a missing acknowledge and reads the word back to confirm that nothing was written. A similar pinpoint drive drops stb in the middle of the acknowledge cycle to show the gating. A reset is also asserted while a request is in flight, to show that the memory keeps its contents.

// File: rtl/wbram_pkg.sv
package wbram_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_ACK  = 2'd2
  } wb_phase_e;

  // power-up byte value for a given byte address
  function automatic logic [7:0] seed_byte(input int unsigned byte_addr,
                                           input int unsigned seed);
    return 8'((byte_addr + seed) % 256);
  endfunction

endpackage

// File: rtl/wbram_front.sv
module wbram_front
  import wbram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 512
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cyc,
  input  logic                    stb,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       adr,
  input  logic [DATA_W/8-1:0]     sel,
  input  logic [DATA_W-1:0]       wdat,
  output logic                    mem_en,
  output logic                    mem_we,
  output logic [$clog2(DEPTH)-1:0] mem_idx,
  output logic [DATA_W/8-1:0]     mem_sel,
  output logic [DATA_W-1:0]       mem_wdat,
  output logic                    ack_q
);
  localparam int SEL_W = DATA_W / 8;
  localparam int LSB   = $clog2(SEL_W);
  localparam int IDX_W = $clog2(DEPTH);

  wb_phase_e phase_q, phase_d;
  logic      req;
  logic      accept;
  logic      adr_unused;

  assign req        = cyc & stb;
  assign accept     = (phase_q == PH_IDLE) & req;
  assign adr_unused = ^adr;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (req) phase_d = PH_HOLD;
      PH_HOLD: phase_d = req ? PH_ACK : PH_IDLE;
      PH_ACK:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      ack_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ack_q   <= mem_en;
    end
  end

  // request capture; held until the memory access
  always_ff @(posedge clk) begin
    if (accept) begin
      mem_we   <= we;
      mem_idx  <= adr[LSB +: IDX_W];
      mem_sel  <= sel;
      mem_wdat <= wdat;
    end
  end

  assign mem_en = (phase_q == PH_HOLD) & req;

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (phase_q == PH_IDLE) && !ack_q);                       // R10
  AST_CANCEL_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HOLD && !req) |=> !ack_q);                      // R9
  AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> (phase_q == PH_IDLE));                               // R5
  AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_IDLE) |=> !ack_q);                              // R4

endmodule

// File: rtl/wbram_store.sv
module wbram_store
  import wbram_pkg::*;
#(
  parameter int          DATA_W = 64,
  parameter int          DEPTH  = 512,
  parameter int unsigned SEED   = 0
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [DATA_W/8-1:0]      sel,
  input  logic [DATA_W-1:0]        wdat,
  output logic [DATA_W-1:0]        rdat
);
  localparam int SEL_W = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [SEL_W-1:0]  lane_wr;

  initial begin
    for (int w = 0; w < DEPTH; w++)
      for (int b = 0; b < SEL_W; b++)
        mem[w][8*b +: 8] = seed_byte(w * SEL_W + b, SEED);
  end

  // per-lane write strobes
  for (genvar g = 0; g < SEL_W; g++) begin : g_lane
    assign lane_wr[g] = en & we & sel[g];
  end

  always_ff @(posedge clk) begin
    if (en) begin
      for (int b = 0; b < SEL_W; b++)
        if (lane_wr[b]) mem[idx][8*b +: 8] <= wdat[8*b +: 8];
      rdat <= mem[idx];
    end
  end

  AST_NO_WRITE_WHEN_READ: assert property (@(posedge clk)
    (en && !we) |-> (lane_wr == '0));                              // R7

endmodule

// File: rtl/wbram_slave.sv
module wbram_slave
  import wbram_pkg::*;
#(
  parameter int          ADDR_W = 32,
  parameter int          DATA_W = 64,
  parameter int          DEPTH  = 512,
  parameter int unsigned SEED   = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_cyc,
  input  logic                  bus_stb,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_adr,
  input  logic [DATA_W/8-1:0]   bus_sel,
  input  logic [DATA_W-1:0]     bus_wdat,
  output logic [DATA_W-1:0]     bus_rdat,
  output logic                  bus_ack
);
  localparam int SEL_W = DATA_W / 8;
  localparam int IDX_W = $clog2(DEPTH);

  logic             mem_en;
  logic             mem_we;
  logic [IDX_W-1:0] mem_idx;
  logic [SEL_W-1:0] mem_sel;
  logic [DATA_W-1:0] mem_wdat;
  logic             ack_q;

  wbram_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_front (
    .clk(clk), .rst(rst), .cyc(bus_cyc), .stb(bus_stb), .we(bus_we),
    .adr(bus_adr), .sel(bus_sel), .wdat(bus_wdat),
    .mem_en(mem_en), .mem_we(mem_we), .mem_idx(mem_idx), .mem_sel(mem_sel),
    .mem_wdat(mem_wdat), .ack_q(ack_q)
  );

  wbram_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SEED(SEED)) u_store (
    .clk(clk), .en(mem_en), .we(mem_we), .idx(mem_idx), .sel(mem_sel),
    .wdat(mem_wdat), .rdat(bus_rdat)
  );

  assign bus_ack = ack_q & bus_cyc & bus_stb;

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);                                         // R5
  AST_ACK_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
    ack_q |-> $past(mem_en));                                      // R4

endmodule

// File: tb/sim_wbram_slave.sv
module sim_wbram_slave;
  localparam int DEPTH = 512;

  logic        clk = 0;
  logic        rst = 1;
  logic        cyc = 0, stb = 0, we = 0;
  logic [31:0] adr = '0;
  logic [7:0]  sel = '0;
  logic [63:0] wdat = '0;
  logic [63:0] rdat;
  logic        ack;
  logic [63:0] model [DEPTH];
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  wbram_slave u0 (
    .clk(clk), .rst(rst), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
    .bus_adr(adr), .bus_sel(sel), .bus_wdat(wdat), .bus_rdat(rdat), .bus_ack(ack)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    cyc = 0; stb = 0; we = 0; sel = '0; wdat = '0;
  endtask

  // read with full protocol checks
  task automatic rd(input string tag, input logic [31:0] a, input logic [7:0] s,
                    input logic [63:0] exp);
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = a; sel = s; wdat = 64'hDEAD_BEEF_CAFE_F00D;
    #0.1 chk({tag, " R4 ack low at request"}, 64'(ack), 64'd0);
    @(negedge clk);
    chk({tag, " R4 ack low after accept"}, 64'(ack), 64'd0);
    @(negedge clk);
    chk({tag, " R4 ack high"}, 64'(ack), 64'd1);
    chk({tag, " R6 data"}, rdat, exp);
    @(negedge clk);
    chk({tag, " R5 ack one cycle"}, 64'(ack), 64'd0);
    idle_bus();
  endtask

  task automatic wr(input string tag, input logic [31:0] a, input logic [7:0] s,
                    input logic [63:0] d);
    int w;
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = a; sel = s; wdat = d;
    @(negedge clk);
    @(negedge clk);
    chk({tag, " R5 write ack"}, 64'(ack), 64'd1);
    @(negedge clk);
    chk({tag, " R5 write ack drops"}, 64'(ack), 64'd0);
    idle_bus();
    w = int'(a[11:3]);
    for (int b = 0; b < 8; b++)
      if (s[b]) model[w][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic t_reset();
    chk("R10 ack low in reset", 64'(ack), 64'd0);
  endtask

  task automatic t_pattern();
    rd("R3 word0", 32'd0, 8'hFF, 64'h0706050403020100);
    rd("R3 word8", 32'd8, 8'hFF, 64'h0F0E0D0C0B0A0908);
  endtask

  task automatic t_lanes();
    wr("R1 byte write", 32'd0, 8'h01, 64'h0F);
    rd("R8 R1 byte readback", 32'd0, 8'hFF, 64'h070605040302010F);
    wr("R1 upper half", 32'd0, 8'hF0, 64'hBAADFEED_00000000);
    rd("R1 upper readback", 32'd0, 8'hFF, 64'hBAADFEED0302010F);
    wr("R8 full write", 32'd8, 8'hFF, 64'h0001020304050607);
    rd("R8 full readback", 32'd8, 8'hFF, 64'h0001020304050607);
  endtask

  task automatic t_sel_read();
    rd("R6 narrow select read", 32'd8, 8'h01, model[1]);
  endtask

  task automatic t_alias();
    rd("R2 low bits ignored", 32'd13, 8'hFF, model[1]);
    rd("R2 high alias", 32'(DEPTH * 8 + 16), 8'hFF, model[2]);
  endtask

  task automatic t_we_low();
    rd("R7 read with data on bus", 32'd24, 8'hFF, model[3]);
    rd("R7 memory unchanged", 32'd24, 8'hFF, model[3]);
  endtask

  task automatic t_cancel();
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = 32'd32; sel = 8'hFF; wdat = 64'h1111_2222_3333_4444;
    @(negedge clk);
    idle_bus();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 no ack after cancel", 64'(ack), 64'd0);
    end
    rd("R9 cancelled write not stored", 32'd32, 8'hFF, model[4]);
  endtask

  task automatic t_gate();
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = 32'd40; sel = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    chk("R11 ack high before gate", 64'(ack), 64'd1);
    stb = 0;
    #0.1 chk("R11 ack gated by stb", 64'(ack), 64'd0);
    cyc = 0;
    @(negedge clk);
    idle_bus();
    rd("R11 next cycle works", 32'd40, 8'hFF, model[5]);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = 32'd48; sel = 8'hFF; wdat = 64'hFFFF_0000_FFFF_0000;
    @(negedge clk);
    rst = 1; idle_bus();
    @(negedge clk);
    rst = 0;
    chk("R10 ack low after reset", 64'(ack), 64'd0);
    rd("R10 memory kept word8", 32'd8, 8'hFF, model[1]);
    rd("R10 memory kept word0", 32'd0, 8'hFF, model[0]);
  endtask

  initial begin
    for (int w = 0; w < DEPTH; w++)
      for (int b = 0; b < 8; b++)
        model[w][8*b +: 8] = 8'((w * 8 + b) % 256);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_pattern();
    t_lanes();
    t_sel_read();
    t_alias();
    t_we_low();
    t_cancel();
    t_gate();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule